// File: doc/BRIEF.md
# Floating-Point Compare, Min/Max and Sign-Injection Unit

This unit handles the floating-point operations that never round. Each operand arrives in a 64-bit register. A single-precision value sits in bits 31:0, and the unit ignores the upper half of a single-precision operand. The three operation groups are:

- **Ordered and equality comparisons.** These return 0 or 1 for the integer register file.
- **Minimum and maximum.** These return one of the two operands, or the canonical NaN.
- **Sign injection.** This builds a result from the magnitude of one operand and a sign derived from both.

A group select, a 3-bit function code and a precision bit pick the operation. The unit registers its outputs, so an issued operation produces a result word and an invalid-operation flag one clock later. The flag is meant for the core's accrued exception flags.

NaN handling depends on the operation:

- Ordered comparisons flag any NaN.
- Equality flags only signaling NaNs.
- Min and max pass the non-NaN operand through.
- Sign injection treats every bit pattern as plain data.

Top module: `fp_cmp_sgnj_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `invalid_flag` are all 0.
- R2: `out_valid` equals the `in_valid` of the previous clock. When `in_valid` is low, `result` and `invalid_flag` keep their values.
- R3: `op_group` encodes 0 as sign injection, 1 as min/max and 2 as compare. `is_double`=1 selects 64-bit operands; `is_double`=0 selects 32-bit operands in bits 31:0. A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the fraction's top bit (bit 22 single, bit 51 double) is 1, and signaling otherwise.
- R4: Sign injection returns the magnitude of `src_a`. The sign is chosen by `func`: 0 takes the sign of `src_b`, 1 takes its inverse, and 2 takes the XOR of both signs. Sign injection never raises `invalid_flag`, for any operand values.
- R5: In compare, `func`=0 means a <= b and `func`=1 means a < b. The answer is in bit 0 and the upper bits are 0. If either operand is any NaN, the result is 0 and `invalid_flag` is 1. -0 and +0 compare equal.
- R6: In compare, `func`=2 means a == b, with -0 equal to +0. Any NaN operand gives 0. `invalid_flag` is 1 only if an operand is a signaling NaN.
- R7: In min/max, `func`=0 returns the lesser operand and `func`=1 returns the greater one. -0 is ordered below +0.
- R8: When exactly one min/max operand is NaN, the unit returns the other operand. When both are NaN, it returns 0x7FC00000 for single or 0x7FF8000000000000 for double. `invalid_flag` is 1 exactly when an operand is a signaling NaN.
- R9: Single-precision results other than compare have bits 63:32 equal to 0. The upper 32 bits of single-precision operands have no effect.
- R10: The following are unsupported encodings: `op_group`=3, `func`>2 in sign injection or compare, and `func`>1 in min/max. Each returns a result of 0 with `invalid_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| is_double | input | 1 | 1 = double precision, 0 = single |
| op_group | input | 2 | Operation group |
| func | input | 3 | Function within the group |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result registered from previous cycle's issue |
| result | output | 64 | Result word |
| invalid_flag | output | 1 | Invalid-operation exception |

## Verification
Some properties are checked by the embedded assertions on every cycle:

- the valid timing and the holding of results while idle;
- sign injection never flagging;
- compare results confined to bit 0;
- ordered compares on NaN returning 0 with the flag set;
- equality staying silent on quiet NaNs;
- both-NaN min/max giving the canonical NaN;
- upper-half zeroing of single-precision results.

The other properties can be shown only by the bench's scenarios, which compare every output against an independent model. These are:

- the actual ordering decisions, including signed zeros, subnormals and equal magnitudes;
- which operand min/max selects;
- the sign chosen by each sign-injection variant;
- the insensitivity to upper operand bits in single precision.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    parameter int REG_W   = 64;
    parameter int SP_W    = 32;
    parameter int DP_EXP  = 11;
    parameter int SP_EXP  = 8;
    parameter int FUNC_W  = 3;
    localparam int MAG_W  = REG_W - 1;

    localparam logic [REG_W-1:0] CANON_DP = 64'h7FF8_0000_0000_0000;
    localparam logic [REG_W-1:0] CANON_SP = 64'h0000_0000_7FC0_0000;

    typedef enum logic [1:0] {
        GRP_SGNJ   = 2'd0,
        GRP_MINMAX = 2'd1,
        GRP_CMP    = 2'd2,
        GRP_RSVD   = 2'd3
    } grp_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opinfo_t;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] result;
        logic             invalid;
    } stage_t;

endpackage

// File: rtl/fp_fmt_class.sv
module fp_fmt_class #(
    parameter int W  = 64,
    parameter int EW = 11
) (
    input  logic [W-1:0] x,
    output logic         sign,
    output logic         nan,
    output logic         snan,
    output logic         zero,
    output logic [W-2:0] mag
);
    localparam int FW = W - EW - 1;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    always_comb begin
        exp_f  = x[W-2 -: EW];
        frac_f = x[FW-1:0];
        sign   = x[W-1];
        mag    = x[W-2:0];
        nan    = (&exp_f) && (|frac_f);
        snan   = nan && !frac_f[FW-1];
        zero   = ~|x[W-2:0];
    end
endmodule

// File: rtl/fp_operand_view.sv
module fp_operand_view
    import fpcmp_pkg::*;
(
    input  logic             is_double,
    input  logic [REG_W-1:0] val,
    output opinfo_t          info
);
    localparam int SP_MAG = SP_W - 1;

    logic             dp_sign, dp_nan, dp_snan, dp_zero;
    logic [MAG_W-1:0] dp_mag;
    logic             sp_sign, sp_nan, sp_snan, sp_zero;
    logic [SP_MAG-1:0] sp_mag;

    fp_fmt_class #(.W(REG_W), .EW(DP_EXP)) u_dp (
        .x(val), .sign(dp_sign), .nan(dp_nan), .snan(dp_snan),
        .zero(dp_zero), .mag(dp_mag)
    );

    fp_fmt_class #(.W(SP_W), .EW(SP_EXP)) u_sp (
        .x(val[SP_W-1:0]), .sign(sp_sign), .nan(sp_nan), .snan(sp_snan),
        .zero(sp_zero), .mag(sp_mag)
    );

    always_comb begin
        if (is_double) begin
            info = '{sign: dp_sign, nan: dp_nan, snan: dp_snan,
                     zero: dp_zero, mag: dp_mag};
        end else begin
            info = '{sign: sp_sign, nan: sp_nan, snan: sp_snan,
                     zero: sp_zero, mag: {{(MAG_W-SP_MAG){1'b0}}, sp_mag}};
        end
    end
endmodule

// File: rtl/fp_order.sv
module fp_order
    import fpcmp_pkg::*;
(
    input  opinfo_t a,
    input  opinfo_t b,
    output logic    lt_total,
    output logic    lt_num,
    output logic    eq_num
);
    logic both_zero;
    logic mag_lt, mag_gt, mag_eq;

    always_comb begin
        both_zero = a.zero && b.zero;
        mag_lt    = a.mag < b.mag;
        mag_gt    = a.mag > b.mag;
        mag_eq    = a.mag == b.mag;
        if (a.sign != b.sign) begin
            lt_total = a.sign;
        end else if (a.sign) begin
            lt_total = mag_gt;
        end else begin
            lt_total = mag_lt;
        end
        lt_num = lt_total && !both_zero;
        eq_num = both_zero || ((a.sign == b.sign) && mag_eq);
    end
endmodule

// File: rtl/fp_sgnj.sv
module fp_sgnj
    import fpcmp_pkg::*;
(
    input  logic              is_double,
    input  logic [FUNC_W-1:0] func,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic [MAG_W-1:0]  mag_a,
    output logic              supported,
    output logic [REG_W-1:0]  res
);
    logic new_sign;

    always_comb begin
        supported = 1'b1;
        case (func)
            3'd0:    new_sign = sign_b;
            3'd1:    new_sign = ~sign_b;
            3'd2:    new_sign = sign_a ^ sign_b;
            default: begin
                new_sign  = 1'b0;
                supported = 1'b0;
            end
        endcase
        if (!supported) begin
            res = '0;
        end else if (is_double) begin
            res = {new_sign, mag_a};
        end else begin
            res = {{(REG_W-SP_W){1'b0}}, new_sign, mag_a[SP_W-2:0]};
        end
    end
endmodule

// File: rtl/fp_cmp_sgnj_unit.sv
module fp_cmp_sgnj_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_double,
    input  logic [1:0]        op_group,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    output logic              out_valid,
    output logic [REG_W-1:0]  result,
    output logic              invalid_flag
);
    opinfo_t          va, vb;
    logic             lt_total, lt_num, eq_num;
    logic             sgnj_ok;
    logic [REG_W-1:0] sgnj_res;
    logic [REG_W-1:0] a_word, b_word, canon;
    grp_e             grp;
    stage_t           st_d, st_q;

    fp_operand_view u_view_a (.is_double(is_double), .val(src_a), .info(va));
    fp_operand_view u_view_b (.is_double(is_double), .val(src_b), .info(vb));

    fp_order u_order (
        .a(va), .b(vb), .lt_total(lt_total), .lt_num(lt_num), .eq_num(eq_num)
    );

    fp_sgnj u_sgnj (
        .is_double(is_double), .func(func), .sign_a(va.sign), .sign_b(vb.sign),
        .mag_a(src_a[MAG_W-1:0]), .supported(sgnj_ok), .res(sgnj_res)
    );

    always_comb begin
        grp    = grp_e'(op_group);
        a_word = is_double ? src_a : {{(REG_W-SP_W){1'b0}}, src_a[SP_W-1:0]};
        b_word = is_double ? src_b : {{(REG_W-SP_W){1'b0}}, src_b[SP_W-1:0]};
        canon  = is_double ? CANON_DP : CANON_SP;

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = '0;
            st_d.invalid = 1'b0;
            case (grp)
                GRP_SGNJ: begin
                    st_d.result = sgnj_res;
                end
                GRP_MINMAX: begin
                    if (func <= 3'd1) begin
                        st_d.invalid = va.snan || vb.snan;
                        if (va.nan && vb.nan) begin
                            st_d.result = canon;
                        end else if (va.nan) begin
                            st_d.result = b_word;
                        end else if (vb.nan) begin
                            st_d.result = a_word;
                        end else if (func == 3'd0) begin
                            st_d.result = lt_total ? a_word : b_word;
                        end else begin
                            st_d.result = lt_total ? b_word : a_word;
                        end
                    end
                end
                GRP_CMP: begin
                    case (func)
                        3'd0: begin
                            st_d.invalid   = va.nan || vb.nan;
                            st_d.result[0] = !st_d.invalid && (lt_num || eq_num);
                        end
                        3'd1: begin
                            st_d.invalid   = va.nan || vb.nan;
                            st_d.result[0] = !st_d.invalid && lt_num;
                        end
                        3'd2: begin
                            st_d.invalid   = va.snan || vb.snan;
                            st_d.result[0] = !va.nan && !vb.nan && eq_num;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign result       = st_q.result;
    assign invalid_flag = st_q.invalid;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ($past(in_valid) && $past(rst_n)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(rst_n)) |-> ($stable(result) && $stable(invalid_flag)));

    // R4
    sgnj_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group == 2'd0) |=> !invalid_flag);

    // R5
    cmp_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group == 2'd2) |=> (result[REG_W-1:1] == '0));

    // R5
    unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group == 2'd2 && func <= 3'd1 && (va.nan || vb.nan))
        |=> (invalid_flag && result == '0));

    // R6
    eq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group == 2'd2 && func == 3'd2 && !va.snan && !vb.snan)
        |=> !invalid_flag);

    // R8
    both_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_group == 2'd1 && func <= 3'd1 && va.nan && vb.nan)
        |=> (result == ($past(is_double) ? CANON_DP : CANON_SP)));

    // R9
    sp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_double) |=> (result[REG_W-1:SP_W] == '0));

endmodule

// File: tb/tb_fp_cmp_sgnj_unit.sv
`timescale 1ns/1ps
module tb_fp_cmp_sgnj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_double = 1'b0;
    logic [1:0]  op_group = 2'd0;
    logic [2:0]  func = 3'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fp_cmp_sgnj_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_double(is_double),
        .op_group(op_group), .func(func), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag)
    );

    task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got flag=%b res=%h expected flag=%b res=%h",
                     tag, got[64], got[63:0], exp[64], exp[63:0]);
        end
    endtask

    function automatic logic ref_nan(input logic [63:0] x, input logic dbl);
        return dbl ? (x[62:52] == 11'h7FF && x[51:0] != 0)
                   : (x[30:23] == 8'hFF && x[22:0] != 0);
    endfunction

    function automatic logic ref_snan(input logic [63:0] x, input logic dbl);
        return ref_nan(x, dbl) && !(dbl ? x[51] : x[22]);
    endfunction

    function automatic logic ref_sign(input logic [63:0] x, input logic dbl);
        return dbl ? x[63] : x[31];
    endfunction

    function automatic logic signed [65:0] ref_key(input logic [63:0] x, input logic dbl,
                                                   input logic total);
        logic [62:0] m;
        logic signed [65:0] k;
        m = dbl ? x[62:0] : {32'b0, x[30:0]};
        k = $signed({3'b0, m});
        if (ref_sign(x, dbl)) k = total ? (-k - 66'sd1) : -k;
        return k;
    endfunction

    function automatic logic [64:0] ref_model(input logic dbl, input logic [1:0] g,
                                              input logic [2:0] f,
                                              input logic [63:0] a, input logic [63:0] b);
        logic na, nb, sna, snb, sa, sb, s;
        logic [63:0] aw, bw;
        logic signed [65:0] ka, kb;
        na = ref_nan(a, dbl);  nb = ref_nan(b, dbl);
        sna = ref_snan(a, dbl); snb = ref_snan(b, dbl);
        sa = ref_sign(a, dbl); sb = ref_sign(b, dbl);
        aw = dbl ? a : {32'b0, a[31:0]};
        bw = dbl ? b : {32'b0, b[31:0]};
        if (g == 2'd0 && f <= 3'd2) begin
            s = (f == 3'd0) ? sb : (f == 3'd1) ? ~sb : (sa ^ sb);
            return dbl ? {1'b0, s, a[62:0]} : {1'b0, 32'b0, s, a[30:0]};
        end
        if (g == 2'd1 && f <= 3'd1) begin
            if (na && nb) return {sna | snb, dbl ? 64'h7FF8000000000000 : 64'h7FC00000};
            if (na) return {sna | snb, bw};
            if (nb) return {sna | snb, aw};
            ka = ref_key(a, dbl, 1'b1); kb = ref_key(b, dbl, 1'b1);
            if (f == 3'd0) return {1'b0, (ka <= kb) ? aw : bw};
            return {1'b0, (ka >= kb) ? aw : bw};
        end
        if (g == 2'd2 && f <= 3'd2) begin
            ka = ref_key(a, dbl, 1'b0); kb = ref_key(b, dbl, 1'b0);
            if (f == 3'd2) return {sna | snb, 63'b0, !na && !nb && ka == kb};
            if (na || nb) return {1'b1, 64'b0};
            if (f == 3'd0) return {1'b0, 63'b0, ka <= kb};
            return {1'b0, 63'b0, ka < kb};
        end
        return 65'b0;
    endfunction

    function automatic string tag_of(input logic [1:0] g, input logic [2:0] f,
                                     input logic [63:0] a, input logic [63:0] b, input logic dbl);
        if (g == 2'd3 || f > 3'd2 || (g == 2'd1 && f == 3'd2)) return "R10";
        if (g == 2'd0) return "R4";
        if (g == 2'd1) return (ref_nan(a, dbl) || ref_nan(b, dbl)) ? "R8" : "R7";
        return (f == 3'd2) ? "R6" : "R5";
    endfunction

    task automatic run_op(input logic dbl, input logic [1:0] g, input logic [2:0] f,
                          input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; is_double = dbl; op_group = g; func = f; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {64'b0, out_valid}, 65'd1);
        check(tag, {invalid_flag, result}, ref_model(dbl, g, f, a, b));
    endtask

    function automatic logic [63:0] pick(input logic dbl);
        logic [63:0] r;
        logic [31:0] hi;
        logic s;
        r = {$urandom, $urandom};
        hi = $urandom;
        s = r[63];
        case ($urandom % 9)
            0: return dbl ? {s, 63'b0} : {hi, s, 31'b0};
            1: return dbl ? {s, 11'h7FF, 52'b0} : {hi, s, 8'hFF, 23'b0};
            2: return dbl ? {s, 11'h7FF, 1'b1, r[50:0]} : {hi, s, 8'hFF, 1'b1, r[21:0]};
            3: return dbl ? {s, 11'h7FF, 1'b0, r[50:1], 1'b1} : {hi, s, 8'hFF, 1'b0, r[21:1], 1'b1};
            4: return dbl ? {s, 11'h000, r[51:0]} : {hi, s, 8'h00, r[22:0]};
            5: return dbl ? {s, 11'h3FF, 50'b0, r[1:0]} : {hi, s, 8'h7F, 21'b0, r[1:0]};
            default: return dbl ? r : {hi, r[31:0]};
        endcase
    endfunction

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {invalid_flag, result}, 65'b0);
        check("R1 valid", {64'b0, out_valid}, 65'd0);
        rst_n = 1'b1;

        // Directed corners
        run_op(1'b1, 2'd1, 3'd0, 64'h0000000000000000, 64'h8000000000000000, "R7 min zeros");
        run_op(1'b1, 2'd1, 3'd1, 64'h8000000000000000, 64'h0000000000000000, "R7 max zeros");
        run_op(1'b0, 2'd1, 3'd0, 64'h7FA00000, 64'h7FC00001, "R8 both nan canon");
        run_op(1'b1, 2'd1, 3'd1, 64'h7FF8000000000001, 64'h3FF0000000000000, "R8 one qnan");
        run_op(1'b0, 2'd1, 3'd0, 64'h3F800000, 64'h7F800001, "R8 snan flag");
        run_op(1'b0, 2'd2, 3'd2, 64'h7FC00000, 64'h7FC00000, "R6 qnan eq");
        run_op(1'b1, 2'd2, 3'd2, 64'h7FF0000000000001, 64'h0, "R6 snan eq");
        run_op(1'b1, 2'd2, 3'd2, 64'h8000000000000000, 64'h0, "R6 signed zero eq");
        run_op(1'b0, 2'd2, 3'd1, 64'h7FC00000, 64'h3F800000, "R5 qnan lt");
        run_op(1'b0, 2'd2, 3'd0, 64'h80000000, 64'h00000000, "R5 zero le");
        run_op(1'b1, 2'd0, 3'd2, 64'hFFF0000000000001, 64'h8000000000000000, "R4 xor snan");
        run_op(1'b0, 2'd0, 3'd1, 64'h7F800001, 64'h00000000, "R4 neg snan");
        run_op(1'b0, 2'd1, 3'd0, 64'hDEADBEEF3F800000, 64'h12345678BF800000, "R9 min upper");
        run_op(1'b0, 2'd2, 3'd2, 64'hAAAAAAAA40000000, 64'h5555555540000000, "R9 eq upper");
        run_op(1'b0, 2'd0, 3'd0, 64'hFFFFFFFF40490FDB, 64'h00000000BF800000, "R9 sgnj upper");
        run_op(1'b1, 2'd3, 3'd0, 64'h7FF0000000000001, 64'h1, "R10 group3");
        run_op(1'b1, 2'd1, 3'd2, 64'h7FF0000000000001, 64'h1, "R10 minmax f2");
        run_op(1'b0, 2'd2, 3'd5, 64'h7F800001, 64'h1, "R10 cmp f5");

        // R2: hold while idle with changing inputs
        run_op(1'b1, 2'd0, 3'd1, 64'h4000000000000000, 64'h0, "R4 hold setup");
        held = result;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
            op_group = 2'($urandom); func = 3'($urandom);
            check("R2 idle valid", {64'b0, out_valid}, 65'd0);
            check("R2 hold", {invalid_flag, result}, {1'b0, held});
        end

        // R3: random mix over all encodings
        for (int i = 0; i < 4000; i++) begin
            logic        dbl;
            logic [1:0]  g;
            logic [2:0]  f;
            logic [63:0] a, b;
            dbl = 1'($urandom);
            g = 2'($urandom);
            f = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 3);
            a = pick(dbl);
            case ($urandom % 4)
                0: b = a;
                1: b = a ^ (dbl ? 64'h8000000000000000 : 64'h80000000);
                default: b = pick(dbl);
            endcase
            run_op(dbl, g, f, a, b, {"R3 ", tag_of(g, f, a, b, dbl)});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule